// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block makes the pass/drop decision for a received Ethernet frame from its destination address alone. The receive path pulses a frame-start strobe and then presents the six destination bytes, in wire order, one per valid cycle. While the bytes arrive, a reflected CRC-32 runs over them at one byte per clock. After the last byte, the block combines four things to reach its verdict: the promiscuous flag, a broadcast check, the group bit of the first byte, and one of two further tests. For a group address, that test is a 64-entry hash table held as four 16-bit words. For an individual address, it is an exact compare against the 48-bit station address.

Software loads the hash table one 16-bit word at a time through a small write port. The verdict appears one clock after the sixth byte. It holds until the next frame-start strobe, so the downstream receive logic can sample it at any time in between.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, decision_valid_o and accept_o are 0 and all four table words are 0.
- R2: The hash index is bits 31..26 of a CRC that starts at 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, takes each byte LSB first, takes the six bytes in arrival order, and applies no final inversion.
- R3: Index bits 5..4 pick the table word, which is written with tbl_addr_i equal to that value. Index bits 3..0 pick the bit inside that word.
- R4: A group frame (bit 0 of the first byte set, not broadcast, promiscuous off) is accepted exactly when its table bit is 1.
- R5: When all four words hold 0xFFFF, every group frame is accepted.
- R6: An individual frame (bit 0 of the first byte clear, promiscuous off) is accepted only when all 48 bits equal station_addr_i. The first byte is compared with bits 47..40.
- R7: The all-ones destination is accepted even when the table is all zero.
- R8: With promisc_i high at the cycle of the sixth byte, the frame is accepted.
- R9: decision_valid_o rises one clock after the sixth byte is taken and is low before that. It stays high with accept_o unchanged until the next frame start. Bytes after the sixth, and table writes, leave it unchanged.
- R10: One clock after frame_start_i, decision_valid_o and accept_o are 0. A byte offered in the same cycle as frame_start_i is not taken.
- R11: Idle cycles (byte_valid_i low) between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table word write strobe |
| tbl_addr_i | input | 2 | Table word select |
| tbl_wdata_i | input | 16 | Table word data |
| promisc_i | input | 1 | Accept every frame |
| station_addr_i | input | 48 | Own address; bits 47..40 are the first byte on the wire |
| frame_start_i | input | 1 | One-cycle pulse that begins a new frame |
| byte_valid_i | input | 1 | byte_i carries a destination byte |
| byte_i | input | 8 | Destination address byte |
| decision_valid_o | output | 1 | Verdict is available |
| accept_o | output | 1 | Frame passes the filter |

## Verification
The verdict is due on the first falling edge after the rising edge that takes the sixth byte. The bench checks that decision_valid_o is still low on the falling edge just before that, and checks the verdict on the falling edge after. Clearing is due one clock after the frame-start strobe, and the bench samples it on the next falling edge. During the hold window, the bench offers surplus bytes and writes the table, then re-reads the verdict on later falling edges to confirm it has not moved. Expected verdicts come from a bench-side CRC and table model. Stimulus is driven on falling edges, so every check sees settled register outputs.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // one byte of reflected CRC, LSB first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
  import mhf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_next_o
);
  logic [CRC_W-1:0] crc_q;

  assign crc_next_o = crc_byte(crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= CRC_INIT;
    else if (en_i)   crc_q <= crc_next_o;
  end
endmodule

// File: rtl/mhf_addr_capture.sv
module mhf_addr_capture #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned ADDR_W = ADDR_BYTES * 8,
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              take_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] dest_next_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;

  assign take_o      = byte_valid_i && !frame_start_i && (cnt_q != CNT_FULL);
  assign last_o      = take_o && (cnt_q == CNT_LAST);
  assign dest_next_o = {addr_q[ADDR_W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_FULL;
      addr_q <= '0;
    end else if (frame_start_i) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (take_o) begin
      cnt_q  <= cnt_q + 1'b1;
      addr_q <= dest_next_o;
    end
  end
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned N_WORDS = 4,
  localparam int unsigned WSEL_W = $clog2(N_WORDS),
  localparam int unsigned BSEL_W = $clog2(WORD_W),
  localparam int unsigned IDX_W  = WSEL_W + BSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WSEL_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              hit_o
);
  logic [WORD_W-1:0] words_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  words_q[w] <= '0;
      else if (we_i && waddr_i == WSEL_W'(w))       words_q[w] <= wdata_i;
    end
  end

  // upper index bits pick the word, lower bits the bit
  assign hit_o = words_q[idx_i[IDX_W-1:BSEL_W]][idx_i[BSEL_W-1:0]];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned N_WORDS    = 4,
  localparam int unsigned ADDR_W = ADDR_BYTES * 8,
  localparam int unsigned WSEL_W = $clog2(N_WORDS),
  localparam int unsigned IDX_W  = WSEL_W + $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [WSEL_W-1:0] tbl_addr_i,
  input  logic [WORD_W-1:0] tbl_wdata_i,
  input  logic              promisc_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              frame_start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              decision_valid_o,
  output logic              accept_o
);
  logic              take, last, hash_hit, accept_d;
  logic [ADDR_W-1:0] dest;
  logic [CRC_W-1:0]  crc_next;
  logic [IDX_W-1:0]  idx;

  mhf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk_i, .rst_ni, .frame_start_i, .byte_valid_i, .byte_i,
    .take_o(take), .last_o(last), .dest_next_o(dest)
  );

  mhf_crc_unit u_crc (
    .clk_i, .rst_ni, .init_i(frame_start_i), .en_i(take), .byte_i,
    .crc_next_o(crc_next)
  );

  assign idx = crc_next[CRC_W-1 -: IDX_W];

  mhf_hash_table #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_tbl (
    .clk_i, .rst_ni, .we_i(tbl_we_i), .waddr_i(tbl_addr_i),
    .wdata_i(tbl_wdata_i), .idx_i(idx), .hit_o(hash_hit)
  );

  // group bit is bit 0 of the first byte, now at the top of dest
  always_comb begin
    if (promisc_i || (&dest))  accept_d = 1'b1;
    else if (dest[ADDR_W-8])   accept_d = hash_hit;
    else                       accept_d = (dest == station_addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
    end else if (frame_start_i) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
    end else if (last) begin
      decision_valid_o <= 1'b1;
      accept_o         <= accept_d;
    end
  end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WSEL_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tbl_we_i,
  input logic [WSEL_W-1:0] tbl_addr_i,
  input logic [WORD_W-1:0] tbl_wdata_i,
  input logic              promisc_i,
  input logic [ADDR_W-1:0] station_addr_i,
  input logic              frame_start_i,
  input logic              byte_valid_i,
  input logic [7:0]        byte_i,
  input logic              decision_valid_o,
  input logic              accept_o
);
  // R10
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (!decision_valid_o && !accept_o));

  // R9
  verdict_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && !frame_start_i) |=> (decision_valid_o && $stable(accept_o)));

  // R9
  verdict_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(decision_valid_o) |-> ($past(byte_valid_i) && !$past(frame_start_i)));

  // R8
  promisc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(decision_valid_o) && $past(promisc_i)) |-> accept_o);

  // R1
  accept_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> decision_valid_o);
endmodule

bind mcast_hash_filter mhf_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
) u_chk (.*);

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [1:0]  tbl_addr_i = '0;
  logic [15:0] tbl_wdata_i = '0;
  logic        promisc_i = 1'b0;
  logic [47:0] station_addr_i = 48'h02_1A_2B_3C_4D_5E;
  logic        frame_start_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        decision_valid_o, accept_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] tbl_m [4];

  always #2.5 clk_i = ~clk_i;

  mcast_hash_filter u_mcast_hash_filter (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] d = a[47-8*b -: 8];
      for (int i = 0; i < 8; i++)
        c = (c[0] ^ d[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bit ref_accept(input logic [47:0] a, input bit pm);
    logic [5:0] ix;
    if (pm || a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[40]) begin
      ix = ref_crc(a)[31:26];
      return tbl_m[ix[5:4]][ix[3:0]];
    end
    return a == station_addr_i;
  endfunction

  task automatic tbl_write(input int w, input logic [15:0] d);
    tbl_we_i = 1'b1; tbl_addr_i = 2'(w); tbl_wdata_i = d;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    tbl_m[w] = d;
  endtask

  task automatic run_frame(input logic [47:0] a, input bit pm, input bit gaps,
                           input int extra, input string req);
    bit exp;
    promisc_i = pm;
    frame_start_i = 1'b1;
    byte_valid_i = 1'b1; byte_i = 8'hA5;  // ignored alongside start
    @(negedge clk_i);
    frame_start_i = 1'b0; byte_valid_i = 1'b0;
    check(!decision_valid_o && !accept_o, "R10", {decision_valid_o, accept_o}, 0);
    for (int b = 0; b < 6; b++) begin
      if (gaps) begin
        for (int g = 0; g < int'($urandom_range(2)); g++) begin
          byte_valid_i = 1'b0; byte_i = 8'($urandom);
          @(negedge clk_i);
        end
      end
      byte_valid_i = 1'b1; byte_i = a[47-8*b -: 8];
      if (b == 5) check(!decision_valid_o, "R9", decision_valid_o, 0);
      @(negedge clk_i);
    end
    byte_valid_i = 1'b0;
    exp = ref_accept(a, pm);
    check(decision_valid_o, "R9", decision_valid_o, 1);
    check(accept_o == exp, req, accept_o, exp);
    for (int e = 0; e < extra; e++) begin
      byte_valid_i = 1'b1; byte_i = 8'($urandom);
      promisc_i = ~pm;
      @(negedge clk_i);
      byte_valid_i = 1'b0;
      check(decision_valid_o && accept_o == exp, "R9", accept_o, exp);
    end
    promisc_i = pm;
  endtask

  function automatic logic [47:0] mcast_at(input int word, input int bitn);
    logic [47:0] a;
    logic [5:0] ix;
    for (int k = 0; k < 100000; k++) begin
      a = {$urandom, $urandom} | 48'h01_0000_0000_00;
      ix = ref_crc(a)[31:26];
      if (ix[5:4] == 2'(word) && ix[3:0] == 4'(bitn) && a != '1) return a;
    end
    return 48'h01_00_5E_00_00_01;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < 4; w++) tbl_m[w] = '0;
    repeat (3) @(negedge clk_i);
    check(!decision_valid_o && !accept_o, "R1", {decision_valid_o, accept_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: empty table rejects a group address
    run_frame(48'h01_00_5E_00_00_FB, 0, 0, 0, "R1");
    // R7: broadcast with empty table
    run_frame('1, 0, 0, 0, "R7");
    // R6: exact match and one-bit miss
    run_frame(station_addr_i, 0, 0, 0, "R6");
    run_frame(station_addr_i ^ 48'h1, 0, 0, 0, "R6");
    run_frame(station_addr_i ^ 48'h0000_8000_0000, 0, 1, 0, "R6");
    // R8: promiscuous passes a foreign unicast
    run_frame(48'h00_11_22_33_44_55, 1, 0, 0, "R8");
    // R3 / R4: one bit per word, its own address accepted, neighbours rejected
    for (int w = 0; w < 4; w++) begin
      int bn = int'($urandom_range(15));
      logic [47:0] a = mcast_at(w, bn);
      for (int k = 0; k < 4; k++) tbl_write(k, '0);
      tbl_write(w, 16'(1) << bn);
      run_frame(a, 0, 0, 0, "R3");
      tbl_write(w, ~(16'(1) << bn));
      run_frame(a, 0, 0, 0, "R4");
    end
    // R2: known address hashes to a bench-computed index
    begin
      logic [47:0] a = 48'h01_00_5E_00_00_01;
      logic [5:0] ix = ref_crc(a)[31:26];
      for (int k = 0; k < 4; k++) tbl_write(k, '0);
      tbl_write(int'(ix[5:4]), 16'(1) << ix[3:0]);
      run_frame(a, 0, 1, 0, "R2");
    end
    // R5: all ones
    for (int k = 0; k < 4; k++) tbl_write(k, 16'hFFFF);
    for (int i = 0; i < 8; i++)
      run_frame({$urandom, $urandom} | 48'h01_0000_0000_00, 0, 1, 0, "R5");
    // R9: surplus bytes and table writes after verdict
    for (int k = 0; k < 4; k++) tbl_write(k, '0);
    run_frame(48'h01_00_5E_7F_00_01, 0, 0, 3, "R9");
    tbl_write(0, 16'hFFFF); tbl_write(1, 16'hFFFF);
    tbl_write(2, 16'hFFFF); tbl_write(3, 16'hFFFF);
    check(decision_valid_o && !accept_o, "R9", accept_o, 0);
    // R11: random mix with gaps
    for (int i = 0; i < 200; i++) begin
      logic [47:0] a;
      int kind = int'($urandom_range(3));
      if (($urandom & 7) == 0) tbl_write(int'($urandom_range(3)), 16'($urandom));
      case (kind)
        0: a = station_addr_i;
        1: a = '1;
        2: a = {$urandom, $urandom} | 48'h01_0000_0000_00;
        default: a = {$urandom, $urandom} & ~48'h01_0000_0000_00;
      endcase
      run_frame(a, ($urandom & 7) == 0, 1, int'($urandom_range(2)), "R11");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule